// File: doc/BRIEF.md
# Secure Boot Erase Sequencer

This block runs once when a device enters its boot-download mode. It reads a protection bit held in the nonvolatile configuration word. If the bit is clear, loading new code is allowed at once. If the bit is set, the block first has the data EEPROM and the RAM wiped and checked. It then clears the configuration word, and only after that does it allow a download. Wiped content cannot be read back by the downloaded code.

Each step is a request/done handshake with an external controller. The EEPROM controller erases and verifies. The RAM controller fills and verifies. A third controller clears the configuration word. A verify that reports failure locks the block until reset. A small combinational filter also screens the reset-mode request. While protection is set, it keeps the part out of the modes that expose the buses.

Top module: `secure_boot_gate`

## Requirements
- R1: After reset, every request output, `dl_en_o`, `busy_o` and `err_o` are low.
- R2: A start pulse with `secure_i` low raises `dl_en_o` at the next clock edge, and no erase or verify request is raised.
- R3: A start pulse with `secure_i` high raises the requests in a fixed order: EEPROM erase, RAM clear, EEPROM verify, RAM verify, configuration erase. At most one request is high at any time. Each request stays high until its own done input is seen at a clock edge.
- R4: The sequence moves on only on the done input of the current step. A done input of any other step, or a verify fail input without its done input, has no effect.
- R5: A verify step that completes with its fail input high moves the block to a locked state. There `err_o` is high and `dl_en_o`, `busy_o` and all requests are low.
- R6: The configuration erase request rises only after both verifies have passed. `dl_en_o` rises only on completion of the configuration erase.
- R7: `busy_o` is high from the edge that takes the start pulse until `dl_en_o` or `err_o` rises, and low otherwise.
- R8: A start pulse while busy, or after `dl_en_o` or `err_o` has risen, is ignored.
- R9: The mode filter uses codes 00 single-chip, 01 expanded, 10 bootstrap, 11 test. With `secure_i` high, codes 01 and 11 are output as 00. All other cases pass the request through unchanged.
- R10: Once high, `dl_en_o` and `err_o` stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| secure_i | input | 1 | Protection bit from the configuration word |
| mode_req_i | input | 2 | Requested reset mode |
| mode_o | output | 2 | Granted reset mode |
| ee_erase_req_o | output | 1 | EEPROM erase request |
| ee_erase_done_i | input | 1 | EEPROM erase finished |
| ram_clr_req_o | output | 1 | RAM fill-with-0xFF request |
| ram_clr_done_i | input | 1 | RAM fill finished |
| ee_vfy_req_o | output | 1 | EEPROM verify request |
| ee_vfy_done_i | input | 1 | EEPROM verify finished |
| ee_vfy_fail_i | input | 1 | EEPROM verify found a byte other than 0xFF |
| ram_vfy_req_o | output | 1 | RAM verify request |
| ram_vfy_done_i | input | 1 | RAM verify finished |
| ram_vfy_fail_i | input | 1 | RAM verify found a byte other than 0xFF |
| cfg_erase_req_o | output | 1 | Configuration word erase request |
| cfg_erase_done_i | input | 1 | Configuration erase finished |
| dl_en_o | output | 1 | Download allowed |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Locked after a verify failure |

## Verification
The protected sequence is driven with every controller latency from zero to three wait cycles. This shows that each step holds its request for exactly as long as its controller takes, and that the order does not depend on timing. Failure is injected at each of the two verify steps, which tells apart the two paths into the locked state. Done inputs of the wrong step, stray start pulses and fail inputs raised without done are applied mid-sequence. These confirm that only the current handshake advances the block. All eight combinations of the mode request and the protection bit are swept through the filter.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int NSTEP  = 5;
  localparam int MODE_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_EE_ERASE  = 3'd1,
    ST_RAM_CLR   = 3'd2,
    ST_EE_VFY    = 3'd3,
    ST_RAM_VFY   = 3'd4,
    ST_CFG_ERASE = 3'd5,
    ST_DL_EN     = 3'd6,
    ST_LOCKED    = 3'd7
  } sbg_state_e;

  localparam logic [MODE_W-1:0] MODE_SINGLE = 2'b00;
  localparam logic [MODE_W-1:0] MODE_EXP    = 2'b01;
  localparam logic [MODE_W-1:0] MODE_BOOT   = 2'b10;
  localparam logic [MODE_W-1:0] MODE_TEST   = 2'b11;
endpackage

// File: rtl/sbg_mode_filter.sv
module sbg_mode_filter
  import sbg_pkg::*;
(
  input  logic              secure_i,
  input  logic [MODE_W-1:0] mode_req_i,
  output logic [MODE_W-1:0] mode_o
);
  logic exposes_bus;

  always_comb begin
    exposes_bus = (mode_req_i == MODE_EXP) || (mode_req_i == MODE_TEST);
    mode_o      = (secure_i && exposes_bus) ? MODE_SINGLE : mode_req_i;
  end
endmodule

// File: rtl/sbg_fsm.sv
module sbg_fsm
  import sbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             secure_i,
  input  logic [NSTEP-1:0] step_done_i,
  input  logic [NSTEP-1:0] step_fail_i,
  output sbg_state_e       state_o
);
  sbg_state_e st_q, st_d;
  logic       st_en;
  logic       in_step;
  logic [2:0] step_idx;

  always_comb begin
    in_step  = (st_q >= ST_EE_ERASE) && (st_q <= ST_CFG_ERASE);
    step_idx = 3'(st_q - ST_EE_ERASE);
    st_d     = st_q;
    if (st_q == ST_IDLE) begin
      if (start_i) st_d = secure_i ? ST_EE_ERASE : ST_DL_EN;
    end else if (in_step) begin
      if (step_done_i[step_idx]) begin
        if (step_fail_i[step_idx]) st_d = ST_LOCKED;
        else                       st_d = sbg_state_e'(3'(st_q + 3'd1));
      end
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/sbg_out_dec.sv
module sbg_out_dec
  import sbg_pkg::*;
(
  input  sbg_state_e       state_i,
  output logic [NSTEP-1:0] step_req_o,
  output logic             dl_en_o,
  output logic             busy_o,
  output logic             err_o
);
  for (genvar k = 0; k < NSTEP; k++) begin : g_req
    assign step_req_o[k] = (state_i == sbg_state_e'(3'(k + 1)));
  end

  always_comb begin
    dl_en_o = (state_i == ST_DL_EN);
    err_o   = (state_i == ST_LOCKED);
    busy_o  = |step_req_o;
  end
endmodule

// File: rtl/secure_boot_gate.sv
module secure_boot_gate
  import sbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              secure_i,
  input  logic [MODE_W-1:0] mode_req_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              ee_erase_req_o,
  input  logic              ee_erase_done_i,
  output logic              ram_clr_req_o,
  input  logic              ram_clr_done_i,
  output logic              ee_vfy_req_o,
  input  logic              ee_vfy_done_i,
  input  logic              ee_vfy_fail_i,
  output logic              ram_vfy_req_o,
  input  logic              ram_vfy_done_i,
  input  logic              ram_vfy_fail_i,
  output logic              cfg_erase_req_o,
  input  logic              cfg_erase_done_i,
  output logic              dl_en_o,
  output logic              busy_o,
  output logic              err_o
);
  sbg_state_e       state;
  logic [NSTEP-1:0] step_done, step_fail, step_req;

  assign step_done = {cfg_erase_done_i, ram_vfy_done_i, ee_vfy_done_i,
                      ram_clr_done_i, ee_erase_done_i};
  assign step_fail = {1'b0, ram_vfy_fail_i, ee_vfy_fail_i, 1'b0, 1'b0};

  sbg_mode_filter u_mode (
    .secure_i   (secure_i),
    .mode_req_i (mode_req_i),
    .mode_o     (mode_o)
  );

  sbg_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .secure_i    (secure_i),
    .step_done_i (step_done),
    .step_fail_i (step_fail),
    .state_o     (state)
  );

  sbg_out_dec u_dec (
    .state_i    (state),
    .step_req_o (step_req),
    .dl_en_o    (dl_en_o),
    .busy_o     (busy_o),
    .err_o      (err_o)
  );

  assign ee_erase_req_o  = step_req[0];
  assign ram_clr_req_o   = step_req[1];
  assign ee_vfy_req_o    = step_req[2];
  assign ram_vfy_req_o   = step_req[3];
  assign cfg_erase_req_o = step_req[4];
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       secure_i,
  input logic [1:0] mode_req_i,
  input logic [1:0] mode_o,
  input logic       ee_erase_req_o,
  input logic       ee_erase_done_i,
  input logic       ram_clr_req_o,
  input logic       ram_clr_done_i,
  input logic       ee_vfy_req_o,
  input logic       ee_vfy_done_i,
  input logic       ee_vfy_fail_i,
  input logic       ram_vfy_req_o,
  input logic       ram_vfy_done_i,
  input logic       ram_vfy_fail_i,
  input logic       cfg_erase_req_o,
  input logic       cfg_erase_done_i,
  input logic       dl_en_o,
  input logic       busy_o,
  input logic       err_o
);
  logic [4:0] reqs;
  logic       any_done;
  assign reqs = {cfg_erase_req_o, ram_vfy_req_o, ee_vfy_req_o, ram_clr_req_o, ee_erase_req_o};
  assign any_done = ee_erase_done_i | ram_clr_done_i | ee_vfy_done_i |
                    ram_vfy_done_i | cfg_erase_done_i;

  assert_reqs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqs));

  assert_ram_clr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_clr_req_o) |-> $past(ee_erase_req_o && ee_erase_done_i));

  assert_ee_vfy_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_vfy_req_o) |-> $past(ram_clr_req_o && ram_clr_done_i));

  assert_ram_vfy_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_vfy_req_o) |-> $past(ee_vfy_req_o && ee_vfy_done_i && !ee_vfy_fail_i));

  assert_cfg_after_verify_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_erase_req_o) |-> $past(ram_vfy_req_o && ram_vfy_done_i && !ram_vfy_fail_i));

  assert_dl_after_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dl_en_o) |-> $past((cfg_erase_req_o && cfg_erase_done_i) ||
                             (!busy_o && start_i && !secure_i)));

  assert_hold_without_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !any_done) |=> $stable(reqs));

  assert_lock_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!dl_en_o && !busy_o && reqs == 5'd0));

  assert_busy_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == (reqs != 5'd0));

  assert_dl_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dl_en_o |=> dl_en_o);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  always_comb begin
    if (rst_n && secure_i)
      assert_mode_screen_R9: assert (mode_o == 2'b00 || mode_o == 2'b10);
  end
endmodule

bind secure_boot_gate sbg_checker u_sbg_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .secure_i(secure_i),
  .mode_req_i(mode_req_i), .mode_o(mode_o),
  .ee_erase_req_o(ee_erase_req_o), .ee_erase_done_i(ee_erase_done_i),
  .ram_clr_req_o(ram_clr_req_o), .ram_clr_done_i(ram_clr_done_i),
  .ee_vfy_req_o(ee_vfy_req_o), .ee_vfy_done_i(ee_vfy_done_i), .ee_vfy_fail_i(ee_vfy_fail_i),
  .ram_vfy_req_o(ram_vfy_req_o), .ram_vfy_done_i(ram_vfy_done_i), .ram_vfy_fail_i(ram_vfy_fail_i),
  .cfg_erase_req_o(cfg_erase_req_o), .cfg_erase_done_i(cfg_erase_done_i),
  .dl_en_o(dl_en_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/tb_secure_boot_gate.sv
module tb_secure_boot_gate;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic start, secure;
  logic [1:0] mode_req, mode_out;
  logic [4:0] dn;
  logic ee_fail, ram_fail;
  logic ee_erase_req, ram_clr_req, ee_vfy_req, ram_vfy_req, cfg_erase_req;
  logic dl_en, busy, err;
  logic [4:0] req;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secure_boot_gate dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .secure_i(secure),
    .mode_req_i(mode_req), .mode_o(mode_out),
    .ee_erase_req_o(ee_erase_req), .ee_erase_done_i(dn[0]),
    .ram_clr_req_o(ram_clr_req), .ram_clr_done_i(dn[1]),
    .ee_vfy_req_o(ee_vfy_req), .ee_vfy_done_i(dn[2]), .ee_vfy_fail_i(ee_fail),
    .ram_vfy_req_o(ram_vfy_req), .ram_vfy_done_i(dn[3]), .ram_vfy_fail_i(ram_fail),
    .cfg_erase_req_o(cfg_erase_req), .cfg_erase_done_i(dn[4]),
    .dl_en_o(dl_en), .busy_o(busy), .err_o(err)
  );

  assign req = {cfg_erase_req, ram_vfy_req, ee_vfy_req, ram_clr_req, ee_erase_req};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // status packed as {dl_en, busy, err} for compact checks
  function automatic int status();
    return {29'd0, dl_en, busy, err};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; secure = 1'b0; dn = '0;
    ee_fail = 1'b0; ram_fail = 1'b0; mode_req = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start(input bit sec);
    secure = sec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // wait `delay` cycles inside step k with verify fail level `fl`, then complete
  task automatic run_step(input int k, input int delay, input bit fl);
    if (k == 2) ee_fail = fl;
    if (k == 3) ram_fail = fl;
    for (int d = 0; d < delay; d++) begin
      check(req == 5'(1 << k) && busy, "R3 R4 request held while waiting", req, 1 << k);
      @(negedge clk);
    end
    check(req == 5'(1 << k), "R3 request before done", req, 1 << k);
    dn[k] = 1'b1;
    @(negedge clk);
    dn[k] = 1'b0; ee_fail = 1'b0; ram_fail = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(req == 5'd0 && status() == 0, "R1 reset outputs", {req, 3'(status())}, 0);

    // R9 mode filter sweep
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 4; m++) begin
        int exp_m;
        secure = s[0]; mode_req = m[1:0];
        #1;
        exp_m = (s == 1 && m[0]) ? 0 : m;
        check(mode_out == 2'(exp_m), "R9 mode filter", mode_out, exp_m);
      end
    end

    // R2 unprotected start
    do_reset();
    pulse_start(1'b0);
    check(status() == 3'b100 && req == 5'd0, "R2 direct download", status(), 3'b100);
    // R8 R10 start after completion ignored
    pulse_start(1'b1);
    repeat (2) @(negedge clk);
    check(status() == 3'b100 && req == 5'd0, "R8 R10 start after dl_en ignored", status(), 3'b100);

    // R3 R6 R7 full protected sequence, latency sweep
    for (int dly = 0; dly < 4; dly++) begin
      do_reset();
      pulse_start(1'b1);
      check(busy && !dl_en, "R7 busy after start", status(), 3'b010);
      for (int k = 0; k < 5; k++) begin
        run_step(k, dly, 1'b0);
        if (k < 4) check(!dl_en, "R6 no download before cfg erase", dl_en, 0);
      end
      check(status() == 3'b100 && req == 5'd0, "R6 R7 download after cfg erase", status(), 3'b100);
    end

    // R4 foreign done and fail without done; R8 start while busy
    do_reset();
    pulse_start(1'b1);
    for (int k = 0; k < 5; k++) begin
      dn = ~5'(1 << k);
      ee_fail = 1'b1; ram_fail = 1'b1;
      @(negedge clk);
      dn = '0; ee_fail = 1'b0; ram_fail = 1'b0;
      check(req == 5'(1 << k), "R4 other done ignored", req, 1 << k);
      pulse_start(1'b0);
      check(req == 5'(1 << k) && !dl_en, "R8 start while busy ignored", req, 1 << k);
      run_step(k, 1, 1'b0);
    end
    check(status() == 3'b100, "R3 sequence completes", status(), 3'b100);

    // R5 failure at each verify step
    for (int fk = 2; fk < 4; fk++) begin
      do_reset();
      pulse_start(1'b1);
      for (int k = 0; k <= fk; k++) run_step(k, 1, k == fk);
      check(status() == 3'b001 && req == 5'd0, "R5 locked after verify fail", status(), 3'b001);
      pulse_start(1'b0);
      dn = 5'b10000;
      repeat (3) @(negedge clk);
      dn = '0;
      check(status() == 3'b001 && req == 5'd0, "R8 R10 lock sticky", status(), 3'b001);
    end

    do_reset();
    check(status() == 0, "R1 reset clears lock", status(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule